// File: doc/BRIEF.md
# Folded Shift-Add Wavelet Analysis Filter Pair

This block splits a stream of unsigned pixels into two half-rate bands, a smooth approximation and a detail band. Each accepted pixel enters a nine-sample window. The low band applies a nine-tap symmetric kernel and the high band applies a seven-tap symmetric kernel, and both kernels share one centre sample. Mirror-image samples are summed once, before any weighting. Each distinct weight is then built from a fixed set of shifts, additions and subtractions, so the block contains no multiplier.

The two large low-band weights are rounded to values that two shift terms can express. Results can therefore differ from exact convolution by a few counts. Every high-band weight is exact. The input is a valid/ready stream. The output is a valid/ready stream that carries both bands together in one transfer.

A transfer happens on a clock edge where valid and ready are both high. Input ready is high while the output register is empty or the consumer is taking its contents. The output holds its data and keeps valid high until the consumer raises out_ready. While the output stalls, no new pixel is taken.

Top module: `wvt_filt_pair`

## Requirements
- R1: Pixels are unsigned 0..255. Let x[n] be the n-th accepted pixel, with n counted from 0 after reset. The low band for pixel n is 10*(x[n]+x[n-8]) - 6*(x[n-1]+x[n-7]) - 28*(x[n-2]+x[n-6]) + 96*(x[n-3]+x[n-5]) + 224*x[n-4].
- R2: The high band for pixel n is -17*(x[n-1]+x[n-7]) + 10*(x[n-2]+x[n-6]) + 107*(x[n-3]+x[n-5]) - 202*x[n-4]. It shares its centre x[n-4] with the low band.
- R3: Each band is presented as a 16-bit two's complement value. A sum above 32767 is clamped to 32767, and a sum below -32768 is clamped to -32768.
- R4: No output is produced for pixels 0 through 7. The first result belongs to pixel 8, the first pixel that completes the window.
- R5: After the window is full, a result is produced for pixels 8, 10, 12 and so on, never for odd n. Both bands travel in the same output transfer.
- R6: out_valid rises in the cycle after the clock edge that accepted the producing pixel, and only after an accepting edge.
- R7: While out_valid is high and out_ready is low, out_valid, out_lo and out_hi stay unchanged and in_ready is low. No pixel is consumed during that time.
- R8: A synchronous reset clears the window to zero and restarts the pixel count. After reset, out_valid is low, both outputs are zero and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take a pixel |
| in_data | input | 8 | Unsigned pixel |
| out_valid | output | 1 | Band pair present |
| out_ready | input | 1 | Consumer takes the band pair |
| out_lo | output | 16 | Low band (approximation), signed |
| out_hi | output | 16 | High band (detail), signed |

## Verification
A misplaced window stage or a wrong pre-add pairing shows up as wrong band values at the first emitted result, pixel 8, or at the next one. A tap weight that is wrong only for large inputs appears only once values are large enough to reach the clamp boundaries, so windows of all-255 pixels and sparse windows of 255s are driven. A wrong fill or phase count moves out_valid by one pixel, which is visible before pixel 10. A wrong stall path either lets data change under a held out_valid or swallows a pixel, and the swallowed pixel corrupts the result two pixels later.

// File: rtl/wvt_pkg.sv
package wvt_pkg;
  // default geometry of the filter pair
  localparam int WVT_PIX_W = 8;
  localparam int WVT_OUT_W = 16;
  localparam int WVT_WIN   = 9;
  // accumulator headroom above the pixel width (largest weight sum 2*106+224 < 2^9, plus pair bit and sign)
  localparam int WVT_GUARD = 11;
endpackage

// File: rtl/wvt_tapline.sv
module wvt_tapline #(
  parameter int DATA_W = 8,
  parameter int WIN    = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] win [WIN]
);
  logic [DATA_W-1:0] hist_q [WIN-1];

  assign win[0] = din;

  for (genvar g = 0; g < WIN-1; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)        hist_q[g] <= '0;
        else if (shift) hist_q[g] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)        hist_q[g] <= '0;
        else if (shift) hist_q[g] <= hist_q[g-1];
      end
    end
    assign win[g+1] = hist_q[g];
  end
endmodule

// File: rtl/wvt_preadd.sv
module wvt_preadd #(
  parameter int DATA_W = 8,
  parameter int WIN    = 9,
  parameter int ACC_W  = 19
) (
  input  logic [DATA_W-1:0]       win [WIN],
  output logic signed [ACC_W-1:0] pair_s [(WIN-1)/2],
  output logic signed [ACC_W-1:0] mid_s
);
  localparam int PAIRS = (WIN-1)/2;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    logic [DATA_W:0] raw;
    assign raw       = {1'b0, win[k]} + {1'b0, win[WIN-1-k]};
    assign pair_s[k] = $signed({{(ACC_W-DATA_W-1){1'b0}}, raw});
  end

  assign mid_s = $signed({{(ACC_W-DATA_W){1'b0}}, win[PAIRS]});
endmodule

// File: rtl/wvt_lo_band.sv
module wvt_lo_band #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 19
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ACC_W-1:0] pair_s [4],
  input  logic signed [ACC_W-1:0] mid_s,
  output logic signed [ACC_W-1:0] lo_sum
);
  localparam int PMAX   = (1 << DATA_W) - 1;
  localparam int LO_TOP = 2*PMAX*(10+96) + 224*PMAX;
  localparam int LO_BOT = -2*PMAX*(6+28);

  logic signed [ACC_W-1:0] t10, tm6, tm28, t96, t224;

  always_comb begin
    t10  =  (pair_s[0] <<< 3) + (pair_s[0] <<< 1);
    tm6  = -(pair_s[1] <<< 3) + (pair_s[1] <<< 1);
    tm28 = -(pair_s[2] <<< 5) + (pair_s[2] <<< 2);
    t96  =  (pair_s[3] <<< 6) + (pair_s[3] <<< 5);
    t224 =  (mid_s     <<< 8) - (mid_s     <<< 5);
    lo_sum = t10 + tm6 + tm28 + t96 + t224;
  end

  AST_LO_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    (int'(lo_sum) <= LO_TOP) && (int'(lo_sum) >= LO_BOT)); // R1
endmodule

// File: rtl/wvt_hi_band.sv
module wvt_hi_band #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 19
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ACC_W-1:0] pair_s [4],
  input  logic signed [ACC_W-1:0] mid_s,
  output logic signed [ACC_W-1:0] hi_sum
);
  localparam int PMAX   = (1 << DATA_W) - 1;
  localparam int HI_TOP = 2*PMAX*(10+107);
  localparam int HI_BOT = -2*PMAX*17 - 202*PMAX;

  logic signed [ACC_W-1:0] tm17, t10, t107, tm202;

  always_comb begin
    tm17  = -(pair_s[1] <<< 4) - pair_s[1];
    t10   =  (pair_s[2] <<< 3) + (pair_s[2] <<< 1);
    t107  =  (pair_s[3] <<< 7) - (pair_s[3] <<< 4) - (pair_s[3] <<< 2) - pair_s[3];
    tm202 = -((mid_s <<< 8) - (mid_s <<< 6) + (mid_s <<< 3) + (mid_s <<< 1));
    hi_sum = tm17 + t10 + t107 + tm202;
  end

  AST_HI_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    (int'(hi_sum) <= HI_TOP) && (int'(hi_sum) >= HI_BOT)); // R2
endmodule

// File: rtl/wvt_ctrl.sv
module wvt_ctrl #(
  parameter int WIN = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic acc,
  output logic emit
);
  localparam int CNT_W = $clog2(WIN);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WIN-1);

  logic [CNT_W-1:0] fill_q;
  logic             odd_q;

  assign emit = (fill_q == FULL) && !odd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
      odd_q  <= 1'b0;
    end else if (acc) begin
      if (fill_q != FULL) fill_q <= fill_q + 1'b1;
      else                odd_q  <= !odd_q;
    end
  end

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (acc && emit) |=> !emit); // R5
endmodule

// File: rtl/wvt_filt_pair.sv
module wvt_filt_pair
  import wvt_pkg::*;
#(
  parameter int DATA_W = WVT_PIX_W,
  parameter int OUT_W  = WVT_OUT_W,
  parameter int WIN    = WVT_WIN
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [DATA_W-1:0]       in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_lo,
  output logic signed [OUT_W-1:0] out_hi
);
  localparam int ACC_W = DATA_W + WVT_GUARD;
  localparam int PAIRS = (WIN-1)/2;
  localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((2**(OUT_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] NEG_LIM = ACC_W'(-(2**(OUT_W-1)));

  function automatic logic signed [OUT_W-1:0] clamp(input logic signed [ACC_W-1:0] v);
    if (v > POS_LIM)      return {1'b0, {(OUT_W-1){1'b1}}};
    else if (v < NEG_LIM) return {1'b1, {(OUT_W-1){1'b0}}};
    else                  return v[OUT_W-1:0];
  endfunction

  logic                    acc, emit;
  logic [DATA_W-1:0]       win [WIN];
  logic signed [ACC_W-1:0] pair_s [PAIRS];
  logic signed [ACC_W-1:0] mid_s, lo_sum, hi_sum;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  wvt_tapline #(.DATA_W(DATA_W), .WIN(WIN)) tap_i (
    .clk(clk), .rst(rst), .shift(acc), .din(in_data), .win(win));

  wvt_preadd #(.DATA_W(DATA_W), .WIN(WIN), .ACC_W(ACC_W)) pre_i (
    .win(win), .pair_s(pair_s), .mid_s(mid_s));

  wvt_lo_band #(.DATA_W(DATA_W), .ACC_W(ACC_W)) lo_i (
    .clk(clk), .rst(rst), .pair_s(pair_s), .mid_s(mid_s), .lo_sum(lo_sum));

  wvt_hi_band #(.DATA_W(DATA_W), .ACC_W(ACC_W)) hi_i (
    .clk(clk), .rst(rst), .pair_s(pair_s), .mid_s(mid_s), .hi_sum(hi_sum));

  wvt_ctrl #(.WIN(WIN)) ctl_i (
    .clk(clk), .rst(rst), .acc(acc), .emit(emit));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_lo    <= '0;
      out_hi    <= '0;
    end else if (acc && emit) begin
      out_valid <= 1'b1;
      out_lo    <= clamp(lo_sum);
      out_hi    <= clamp(hi_sum);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lo) && $stable(out_hi))); // R7
  AST_RISE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(acc)); // R6
endmodule

// File: tb/wvt_filt_pair_tb.sv
`timescale 1ns/1ps
module wvt_filt_pair_tb_top;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [7:0]        in_data = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic signed [15:0] out_lo, out_hi;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wvt_filt_pair dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_lo(out_lo), .out_hi(out_hi));

  localparam int NSTIM = 24;
  localparam logic [7:0] STIM [NSTIM] = '{
    8'd12, 8'd200, 8'd7, 8'd0, 8'd255, 8'd128, 8'd64, 8'd33,
    8'd90, 8'd1, 8'd250, 8'd17, 8'd140, 8'd0, 8'd0, 8'd99,
    8'd180, 8'd45, 8'd3, 8'd222, 8'd77, 8'd160, 8'd8, 8'd255};

  // independent model state
  int hist [9];
  int nacc;
  bit exp_v;
  int exp_lo, exp_hi;

  function automatic int sat16(input int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 9; i++) hist[i] = 0;
    nacc = 0;
  endtask

  task automatic model_push(input int x);
    for (int i = 8; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    exp_v  = (nacc >= 8) && (((nacc - 8) % 2) == 0);
    exp_lo = sat16(10*(hist[0]+hist[8]) - 6*(hist[1]+hist[7]) - 28*(hist[2]+hist[6])
                   + 96*(hist[3]+hist[5]) + 224*hist[4]);
    exp_hi = sat16(-17*(hist[1]+hist[7]) + 10*(hist[2]+hist[6])
                   + 107*(hist[3]+hist[5]) - 202*hist[4]);
    nacc++;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    model_reset();
  endtask

  // push one pixel with out_ready high and compare against the model
  task automatic send(input int x, input string tag);
    @(negedge clk); in_valid = 1'b1; in_data = x[7:0];
    @(posedge clk); #1; in_valid = 1'b0;
    model_push(x);
    chk(out_valid == exp_v, {tag, " R4/R5/R6 valid"}, int'(out_valid), int'(exp_v));
    if (exp_v) begin
      chk(int'(out_lo) == exp_lo, {tag, " R1 lo"}, int'(out_lo), exp_lo);
      chk(int'(out_hi) == exp_hi, {tag, " R2 hi"}, int'(out_hi), exp_hi);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int held_lo, held_hi;
    // R8: reset state
    do_reset();
    #1;
    chk(out_valid == 1'b0, "R8 valid after reset", int'(out_valid), 0);
    chk(out_lo == 16'sd0, "R8 lo after reset", int'(out_lo), 0);
    chk(out_hi == 16'sd0, "R8 hi after reset", int'(out_hi), 0);
    chk(in_ready == 1'b1, "R8 ready after reset", int'(in_ready), 1);

    // table walk: R1, R2, R4, R5, R6
    for (int i = 0; i < NSTIM; i++) send(int'(STIM[i]), "table");

    // R3: all-255 window saturates low band, high band -510
    do_reset();
    for (int i = 0; i < 12; i++) send(255, "R3 flat");
    chk(int'(out_lo) == 32767, "R3 lo clamp high", int'(out_lo), 32767);
    chk(int'(out_hi) == -510, "R3 hi flat", int'(out_hi), -510);

    // R3: sparse window drives high band below -32768 at pixel 8
    do_reset();
    for (int i = 0; i < 9; i++) send((i == 1 || i == 4 || i == 7) ? 255 : 0, "R3 sparse");
    chk(int'(out_hi) == -32768, "R3 hi clamp low", int'(out_hi), -32768);
    chk(int'(out_lo) == 32767, "R3 lo sparse clamp", int'(out_lo), 32767);

    // R7: back-pressure holds data and takes no pixel
    do_reset();
    for (int i = 0; i < 8; i++) send(10*i + 5, "R7 fill");
    @(negedge clk); out_ready = 1'b0; in_valid = 1'b1; in_data = 8'd77;
    @(posedge clk); #1;
    model_push(77);
    chk(out_valid == 1'b1, "R7 valid at pixel 8", int'(out_valid), 1);
    chk(int'(out_lo) == exp_lo, "R7 lo at pixel 8", int'(out_lo), exp_lo);
    held_lo = int'(out_lo); held_hi = int'(out_hi);
    @(negedge clk); in_data = 8'd200;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); #1;
      chk(in_ready == 1'b0, "R7 ready low in stall", int'(in_ready), 0);
      chk(out_valid == 1'b1 && int'(out_lo) == held_lo && int'(out_hi) == held_hi,
          "R7 hold in stall", int'(out_lo), held_lo);
    end
    @(negedge clk); out_ready = 1'b1;
    @(posedge clk); #1; in_valid = 1'b0;
    model_push(200);
    chk(out_valid == 1'b0, "R7 no result for pixel 9", int'(out_valid), 0);
    send(33, "R7 after stall");

    // R8 and R4: reset mid-stream empties the window
    for (int i = 0; i < 3; i++) send(150, "R8 pre");
    do_reset();
    for (int i = 0; i < 8; i++) send(9, "R8 R4 refill");
    send(9, "R8 R4 first");
    chk(int'(out_lo) == 9*368, "R1 flat 9 lo", int'(out_lo), 9*368);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule